// File: doc/BRIEF.md
# Priority Packet Transmit Scheduler

This block sits between a set of per-source outgoing packet queues and one shared packet output. Each queue reports how many words it holds, the word length of the packet at its head, and its head word (the queue shows its head word without a read, and pops one word per read strobe). The scheduler picks one queue, drains exactly one packet from it word by word, marks the first and last words, and then picks again.

The work is split between two state machines. The judging machine looks only at queues whose word count already covers their whole head packet. Among those it grants the lowest-numbered queue and hands the grant to the transmit machine with a one-cycle send strobe. The transmit machine streams the packet under output backpressure and returns a done strobe on the last accepted word. When another queue is ready at that moment, the judging machine grants it in the same cycle, so the next packet follows with no idle cycle. Both machines use one-hot state codes. The asynchronous reset is released through a local two-stage synchronizer.

Top module: `tlp_tx_sched`

## Requirements
- R1: A queue is eligible only when its head length is nonzero and its word count is at least its head length. A queue holding part of a packet is never started, and a lower-priority complete queue is served ahead of it.
- R2: Among eligible queues, the one with the lowest index is granted (queue 0 highest).
- R3: A grant lasts for the whole packet. Queues that become eligible during a packet, including higher-priority ones, wait until that packet is done and are then chosen by R2.
- R4: A word is transferred only in a cycle with `tx_valid` and `tx_ready` both high. In that cycle the bit of `q_rd_en` for the granted queue is high, and no other bit is. While `tx_ready` is low, the data, `tx_sop` and `tx_eop` hold.
- R5: `tx_sop` marks the first word and `tx_eop` marks the last word of each packet. A one-word packet carries both.
- R6: When a different queue is eligible in the cycle the last word is accepted, its first word is presented in the very next cycle. The queue just served is not reconsidered in that cycle, so two packets from the same queue are separated by exactly one idle cycle.
- R7: While reset is asserted (asynchronously, at once), `tx_valid`, `tx_sop`, `tx_eop` and `q_rd_en` are low and both machines are idle. After reset the block resumes normal scheduling.
- R8: Exactly head-length words are taken from the granted queue per packet, and the output is idle once all queues are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_rd_count | input | NQ*CNTW | Word count of each queue, queue i at bits [i*CNTW +: CNTW] |
| q_head_len | input | NQ*LENW | Word length of each queue's head packet, queue i at [i*LENW +: LENW] |
| q_data | input | NQ*DW | Head word of each queue, queue i at [i*DW +: DW] |
| q_rd_en | output | NQ | Pop strobe, bit i pops queue i |
| tx_data | output | DW | Output word |
| tx_valid | output | 1 | Output word valid |
| tx_ready | input | 1 | Downstream accepts the word this cycle |
| tx_sop | output | 1 | First word of a packet |
| tx_eop | output | 1 | Last word of a packet |

## Verification
The bench goes after the handover between packets. If the done-cycle rearbitration were missing, a gap would appear between packets from different queues. If the served queue were not masked, it would be regranted on a stale length and garble the next packet. It loads a partial packet on a high-priority queue to catch a scheduler that starts on occupancy alone and would then emit words that do not exist yet. It also adds higher-priority work in the middle of a packet, which exposes a grant that switches before done, and it uses one-word packets and stalled outputs where sop/eop and pop strobes most easily slip by one word.

// File: rtl/tlp_sched_pkg.sv
package tlp_sched_pkg;

  typedef enum logic [1:0] {
    JUDGE_IDLE = 2'b01,
    JUDGE_BUSY = 2'b10
  } judge_state_e;

  typedef enum logic [1:0] {
    XMIT_IDLE = 2'b01,
    XMIT_MOVE = 2'b10
  } xmit_state_e;

endpackage

// File: rtl/tlp_rst_sync.sv
module tlp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tlp_prio_pick.sv
module tlp_prio_pick #(
  parameter int NQ   = 4,
  parameter int IDXW = 2
) (
  input  logic [NQ-1:0]   req_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDXW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/tlp_judge.sv
module tlp_judge
  import tlp_sched_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int LENW = 8,
  parameter int CNTW = 9,
  parameter int IDXW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NQ*CNTW-1:0] rd_count_i,
  input  logic [NQ*LENW-1:0] head_len_i,
  input  logic              done_i,
  output logic              send_o,
  output logic [IDXW-1:0]   gnt_o,
  output logic [LENW-1:0]   len_o
);
  localparam int CMPW = (CNTW > LENW) ? CNTW : LENW;

  judge_state_e    state_q, state_d;
  logic [IDXW-1:0] gnt_q;
  logic [NQ-1:0]   mask, elig;
  logic            any_elig, arb_en;
  logic [IDXW-1:0] pick;

  always_comb begin
    mask = '1;
    if (state_q == JUDGE_BUSY) mask[gnt_q] = 1'b0;
  end

  for (genvar g = 0; g < NQ; g++) begin : g_elig
    logic [LENW-1:0] len_w;
    logic [CNTW-1:0] cnt_w;
    assign len_w   = head_len_i[g*LENW +: LENW];
    assign cnt_w   = rd_count_i[g*CNTW +: CNTW];
    assign elig[g] = mask[g] && (len_w != '0) && (CMPW'(cnt_w) >= CMPW'(len_w));
  end

  tlp_prio_pick #(.NQ(NQ), .IDXW(IDXW)) u_pick (
    .req_i (elig),
    .any_o (any_elig),
    .idx_o (pick)
  );

  assign arb_en = (state_q == JUDGE_IDLE) || ((state_q == JUDGE_BUSY) && done_i);
  assign send_o = arb_en && any_elig;
  assign gnt_o  = pick;
  assign len_o  = head_len_i[pick*LENW +: LENW];

  always_comb begin
    state_d = state_q;
    case (state_q)
      JUDGE_IDLE: if (send_o) state_d = JUDGE_BUSY;
      JUDGE_BUSY: if (done_i) state_d = send_o ? JUDGE_BUSY : JUDGE_IDLE;
      default:    state_d = JUDGE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= JUDGE_IDLE;
      gnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (send_o) gnt_q <= pick;
    end
  end

  assert_grant_hold_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == JUDGE_BUSY && !done_i) |=> $stable(gnt_q));

  assert_done_in_busy_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (state_q == JUDGE_BUSY));

  assert_onehot_state_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q));
endmodule

// File: rtl/tlp_xmit.sv
module tlp_xmit
  import tlp_sched_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int LENW = 8,
  parameter int IDXW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            send_i,
  input  logic [IDXW-1:0] gnt_i,
  input  logic [LENW-1:0] len_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic            sop_o,
  output logic            eop_o,
  output logic [NQ-1:0]   rd_en_o,
  output logic [IDXW-1:0] gnt_o,
  output logic            done_o
);
  xmit_state_e     state_q, state_d;
  logic [LENW-1:0] rem_q, rem_d;
  logic [IDXW-1:0] gnt_q, gnt_d;
  logic            first_q, first_d;
  logic            beat, last;

  assign beat = (state_q == XMIT_MOVE) && ready_i;
  assign last = (rem_q == LENW'(1));

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    gnt_d   = gnt_q;
    first_d = first_q;
    case (state_q)
      XMIT_IDLE: begin
        if (send_i) begin
          state_d = XMIT_MOVE;
          rem_d   = len_i;
          gnt_d   = gnt_i;
          first_d = 1'b1;
        end
      end
      XMIT_MOVE: begin
        if (beat) begin
          if (last) begin
            if (send_i) begin
              rem_d   = len_i;
              gnt_d   = gnt_i;
              first_d = 1'b1;
            end else begin
              state_d = XMIT_IDLE;
            end
          end else begin
            rem_d   = rem_q - LENW'(1);
            first_d = 1'b0;
          end
        end
      end
      default: state_d = XMIT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XMIT_IDLE;
      rem_q   <= '0;
      gnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      gnt_q   <= gnt_d;
      first_q <= first_d;
    end
  end

  always_comb begin
    rd_en_o = '0;
    if (beat) rd_en_o[gnt_q] = 1'b1;
  end

  assign valid_o = (state_q == XMIT_MOVE);
  assign sop_o   = valid_o && first_q;
  assign eop_o   = valid_o && last;
  assign gnt_o   = gnt_q;
  assign done_o  = beat && last;

  assert_rd_onehot_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_en_o));

  assert_rd_on_beat_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o != '0) |-> (valid_o && ready_i));

  assert_stall_hold_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(sop_o) && $stable(eop_o) && $stable(gnt_o)));

  assert_onehot_state_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q));
endmodule

// File: rtl/tlp_tx_sched.sv
module tlp_tx_sched #(
  parameter int NQ   = 4,
  parameter int DW   = 64,
  parameter int LENW = 8,
  parameter int CNTW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ*CNTW-1:0] q_rd_count,
  input  logic [NQ*LENW-1:0] q_head_len,
  input  logic [NQ*DW-1:0]   q_data,
  output logic [NQ-1:0]     q_rd_en,
  output logic [DW-1:0]     tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_sop,
  output logic              tx_eop
);
  localparam int IDXW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int CMPW = (CNTW > LENW) ? CNTW : LENW;

  logic            rst_s;
  logic            j_send, x_done;
  logic [IDXW-1:0] j_gnt, x_gnt;
  logic [LENW-1:0] j_len;

  tlp_rst_sync u_rst (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  tlp_judge #(.NQ(NQ), .LENW(LENW), .CNTW(CNTW), .IDXW(IDXW)) u_judge (
    .clk_i      (clk),
    .rst_ni     (rst_s),
    .rd_count_i (q_rd_count),
    .head_len_i (q_head_len),
    .done_i     (x_done),
    .send_o     (j_send),
    .gnt_o      (j_gnt),
    .len_o      (j_len)
  );

  tlp_xmit #(.NQ(NQ), .LENW(LENW), .IDXW(IDXW)) u_xmit (
    .clk_i   (clk),
    .rst_ni  (rst_s),
    .send_i  (j_send),
    .gnt_i   (j_gnt),
    .len_i   (j_len),
    .ready_i (tx_ready),
    .valid_o (tx_valid),
    .sop_o   (tx_sop),
    .eop_o   (tx_eop),
    .rd_en_o (q_rd_en),
    .gnt_o   (x_gnt),
    .done_o  (x_done)
  );

  assign tx_data = q_data[x_gnt*DW +: DW];

  assert_send_elig_R1 : assert property (@(posedge clk) disable iff (!rst_s)
    j_send |-> ((q_head_len[j_gnt*LENW +: LENW] != '0) &&
                (CMPW'(q_rd_count[j_gnt*CNTW +: CNTW]) >= CMPW'(q_head_len[j_gnt*LENW +: LENW]))));

  assert_sop_once_R5 : assert property (@(posedge clk) disable iff (!rst_s)
    (tx_valid && tx_ready && tx_sop && !tx_eop) |=> (tx_valid && !tx_sop));
endmodule

// File: tb/tlp_tx_sched_tb_top.sv
module tlp_tx_sched_tb_top;
  localparam int NQ   = 4;
  localparam int DW   = 64;
  localparam int LENW = 8;
  localparam int CNTW = 9;
  localparam int QD   = 64;

  // vector: len0,len1,len2,len3 (4b each), ready mode (2b), first queue (2b), span (8b, 0 = skip)
  localparam logic [27:0] VECS [8] = '{
    {4'd3, 4'd0, 4'd0, 4'd0, 2'd0, 2'd0, 8'd3},
    {4'd0, 4'd0, 4'd0, 4'd5, 2'd0, 2'd3, 8'd5},
    {4'd2, 4'd4, 4'd1, 4'd3, 2'd0, 2'd0, 8'd10},
    {4'd1, 4'd1, 4'd1, 4'd1, 2'd0, 2'd0, 8'd4},
    {4'd0, 4'd6, 4'd0, 4'd2, 2'd0, 2'd1, 8'd8},
    {4'd4, 4'd3, 4'd2, 4'd1, 2'd1, 2'd0, 8'd0},
    {4'd1, 4'd0, 4'd7, 4'd0, 2'd2, 2'd0, 8'd0},
    {4'd0, 4'd2, 4'd0, 4'd0, 2'd1, 2'd1, 8'd0}
  };

  logic              clk, rst_n, tx_ready;
  logic [NQ*CNTW-1:0] q_rd_count;
  logic [NQ*LENW-1:0] q_head_len;
  logic [NQ*DW-1:0]   q_data;
  logic [NQ-1:0]     q_rd_en;
  logic [DW-1:0]     tx_data;
  logic              tx_valid, tx_sop, tx_eop;

  logic [DW-1:0] mem  [NQ][QD];
  int            lenm [NQ][QD];
  int            wrp [NQ];
  int            rdp [NQ];

  logic [DW-1:0] sb_data [512];
  logic          sb_sop  [512];
  logic          sb_eop  [512];
  int sb_cnt, sb_ptr;
  int checks, fails, cyc, mode;
  int first_cyc, last_cyc, first_q;

  tlp_tx_sched #(.NQ(NQ), .DW(DW), .LENW(LENW), .CNTW(CNTW)) dut_i (
    .clk(clk), .rst_n(rst_n), .q_rd_count(q_rd_count), .q_head_len(q_head_len),
    .q_data(q_data), .q_rd_en(q_rd_en), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      q_rd_count[q*CNTW +: CNTW] = CNTW'(wrp[q] - rdp[q]);
      q_head_len[q*LENW +: LENW] = LENW'(lenm[q][rdp[q] % QD]);
      q_data[q*DW +: DW]         = mem[q][rdp[q] % QD];
    end
  end

  always @(posedge clk) begin
    for (int q = 0; q < NQ; q++) if (q_rd_en[q]) rdp[q] <= rdp[q] + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(input int q, input int tag, input int idx);
    return {40'd0, 8'(q), 8'(tag), 8'(idx)};
  endfunction

  task automatic push_words(input int q, input int len, input int tag, input int from, input int to);
    for (int i = from; i < to; i++) begin
      mem[q][wrp[q] % QD]  = word(q, tag, i);
      lenm[q][wrp[q] % QD] = len;
      wrp[q]++;
    end
  endtask

  task automatic expect_pkt(input int q, input int len, input int tag);
    for (int i = 0; i < len; i++) begin
      sb_data[sb_cnt] = word(q, tag, i);
      sb_sop[sb_cnt]  = (i == 0);
      sb_eop[sb_cnt]  = (i == len - 1);
      sb_cnt++;
    end
  endtask

  task automatic wait_done();
    while (sb_ptr < sb_cnt) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_idle(input string req);
    int occ;
    occ = 0;
    for (int q = 0; q < NQ; q++) occ += wrp[q] - rdp[q];
    check(tx_valid == 1'b0, req, "output idle after traffic", longint'(tx_valid), 0);
    check(occ == 0, req, "words left in queues", occ, 0);
  endtask

  // beat monitor: sets ready for the next edge, then samples
  always @(negedge clk) begin
    cyc++;
    case (mode)
      0:       tx_ready = 1'b1;
      1:       tx_ready = cyc[0];
      default: tx_ready = (cyc % 3 == 0);
    endcase
    #1;
    if (rst_n && tx_valid && tx_ready) begin
      if (sb_ptr >= sb_cnt) begin
        check(1'b0, "R8", "unexpected extra word", longint'(tx_data), 0);
      end else begin
        if (first_cyc < 0) begin
          first_cyc = cyc;
          first_q   = int'(tx_data[23:16]);
        end
        last_cyc = cyc;
        check(tx_data == sb_data[sb_ptr], "R3/R8", "word data", longint'(tx_data), longint'(sb_data[sb_ptr]));
        check(tx_sop == sb_sop[sb_ptr] && tx_eop == sb_eop[sb_ptr], "R5", "sop/eop",
              longint'({tx_sop, tx_eop}), longint'({sb_sop[sb_ptr], sb_eop[sb_ptr]}));
        check(q_rd_en == NQ'(1 << sb_data[sb_ptr][23:16]), "R4", "pop strobe",
              longint'(q_rd_en), longint'(1 << sb_data[sb_ptr][23:16]));
        sb_ptr++;
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; mode = 0;
    sb_cnt = 0; sb_ptr = 0; first_cyc = -1; last_cyc = 0; first_q = 0;
    tx_ready = 1'b1;
    for (int q = 0; q < NQ; q++) begin
      wrp[q] = 0; rdp[q] = 0;
      for (int k = 0; k < QD; k++) begin mem[q][k] = '0; lenm[q][k] = 0; end
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(tx_valid == 0 && q_rd_en == 0 && tx_sop == 0 && tx_eop == 0, "R7", "outputs in reset",
          longint'({tx_valid, q_rd_en, tx_sop, tx_eop}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R2 priority order, R6 gap-free spans
    for (int v = 0; v < 8; v++) begin
      int lens [NQ];
      int vmode, vfirst, vspan;
      lens[0] = int'(VECS[v][27:24]); lens[1] = int'(VECS[v][23:20]);
      lens[2] = int'(VECS[v][19:16]); lens[3] = int'(VECS[v][15:12]);
      vmode = int'(VECS[v][11:10]); vfirst = int'(VECS[v][9:8]); vspan = int'(VECS[v][7:0]);
      mode = vmode;
      first_cyc = -1;
      for (int q = 0; q < NQ; q++) begin
        if (lens[q] != 0) begin
          push_words(q, lens[q], v, 0, lens[q]);
          expect_pkt(q, lens[q], v);
        end
      end
      wait_done();
      check(first_q == vfirst, "R2", "first queue served", first_q, vfirst);
      if (vspan != 0)
        check(last_cyc - first_cyc + 1 == vspan, "R6", "span without gaps", last_cyc - first_cyc + 1, vspan);
      check_idle("R8");
    end

    // R3: higher-priority arrivals mid-packet wait, then follow without gap (R6)
    mode = 0; first_cyc = -1;
    push_words(2, 4, 20, 0, 4); expect_pkt(2, 4, 20);
    while (sb_ptr < sb_cnt - 2) @(negedge clk);
    push_words(1, 2, 21, 0, 2);
    push_words(0, 1, 22, 0, 1);
    expect_pkt(0, 1, 22); expect_pkt(1, 2, 21);
    wait_done();
    check(first_q == 2, "R3", "grant kept on queue 2", first_q, 2);
    check(last_cyc - first_cyc + 1 == 7, "R6", "handover to other queues gap-free", last_cyc - first_cyc + 1, 7);

    // R6: two packets from the same queue leave one idle cycle
    first_cyc = -1;
    push_words(0, 2, 30, 0, 2); push_words(0, 3, 31, 0, 3);
    expect_pkt(0, 2, 30); expect_pkt(0, 3, 31);
    wait_done();
    check(last_cyc - first_cyc + 1 == 6, "R6", "same-queue span with one gap", last_cyc - first_cyc + 1, 6);

    // R1: a partial packet on queue 0 is skipped; complete queue 2 goes first
    first_cyc = -1;
    push_words(0, 4, 40, 0, 3);
    push_words(2, 2, 41, 0, 2); expect_pkt(2, 2, 41);
    wait_done();
    repeat (5) @(negedge clk);
    #2;
    check(tx_valid == 0, "R1", "partial packet not started", longint'(tx_valid), 0);
    check(first_q == 2, "R1", "complete lower-priority queue served", first_q, 2);
    @(negedge clk);
    first_cyc = -1;
    push_words(0, 4, 40, 3, 4); expect_pkt(0, 4, 40);
    wait_done();
    check(first_q == 0, "R1", "queue 0 served once complete", first_q, 0);
    check_idle("R8");

    // R7: reset in the middle of a stalled packet
    mode = 1; first_cyc = -1;
    push_words(3, 8, 50, 0, 8); expect_pkt(3, 8, 50);
    while (sb_ptr < sb_cnt - 5) @(negedge clk);
    rst_n = 1'b0;
    #2;
    check(tx_valid == 0 && q_rd_en == 0, "R7", "outputs drop at reset",
          longint'({tx_valid, q_rd_en}), 0);
    for (int q = 0; q < NQ; q++) rdp[q] = wrp[q];
    sb_ptr = sb_cnt;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mode = 0; first_cyc = -1;
    push_words(1, 2, 51, 0, 2); expect_pkt(1, 2, 51);
    wait_done();
    check(first_q == 1, "R7", "scheduling resumes after reset", first_q, 1);
    check_idle("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule